// File: doc/BRIEF.md
# Pipelined Piecewise-Linear Function Evaluator

This block evaluates a numerical function approximated by straight-line pieces. For each input sample it receives an unsigned fixed-point value `x` and the number of the segment that `x` falls in. It returns `y = slope * (x - start) + base`, where `start`, `slope` and `base` belong to that segment. The per-segment coefficients sit in a small memory that is written through a dedicated write port. Each entry holds:

- the segment start;
- a slope stored as an unsigned magnitude, a sign flag and a left-shift exponent;
- a signed intercept. The intercept already includes the vertical correction that balances the largest positive and negative approximation errors over the segment.

The input is re-based to the segment start before the multiply, so that the unsigned multiplier works on the offset inside the segment. Every unit has a register after it: the table read, the subtractor, the multiplier, an optional shifter, an optional negator and the final adder. One sample enters per cycle. Two parameters remove the optional shifter and negator, which shortens the latency. Choosing the segments and their coefficients is done elsewhere.

Top module: `pwl_eval`

## Requirements
- R1: While `rst` is high at a clock edge, and after it is released, `out_valid` is 0 and `out_y` is 0 until the first result arrives.
- R2: `out_valid` equals `in_valid` delayed by exactly 4 + USE_SHIFT + USE_NEG clock cycles. A new sample may be presented on every cycle.
- R3: For an entry with sign flag 0 (positive), `out_y` = (base + T) mod 2^YW, where T = floor(d * mag * 2^sh / 2^MF), d = (x - start) mod 2^XW, and base is a YW-bit two's-complement value. The result depends only on `x` and the addressed entry.
- R4: With USE_NEG=1 and the sign flag set to 1 (negative), `out_y` = (base - T) mod 2^YW. The magnitude is truncated before negation, so the result rounds toward zero.
- R5: With USE_SHIFT=1, the shift field `sh` (0 to 2^SHW-1) multiplies the product by 2^sh before the MF low bits are dropped.
- R6: A write stores start, mag, sh, sign and base at entry `wr_addr` on the clock edge where `wr_en` is 1. A sample taken on that same edge still sees the old entry. Samples on later edges see the new entry. Other entries are left unchanged.
- R7: On any cycle where `out_valid` is 0, `out_y` keeps the value it had on the previous cycle.
- R8: With USE_SHIFT=0 the shift field is ignored (treated as 0). With USE_NEG=0 the sign flag is ignored (treated as positive).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the valid chain and output |
| in_valid | input | 1 | Sample present on `in_x` / `in_idx` |
| in_x | input | XW | Unsigned fixed-point input, MF-independent scale shared with `start` |
| in_idx | input | AW | Segment number for `in_x` |
| wr_en | input | 1 | Write one coefficient entry |
| wr_addr | input | AW | Entry written |
| wr_start | input | XW | Segment start |
| wr_mag | input | MW | Slope magnitude, MF fractional bits |
| wr_shift | input | SHW | Slope left-shift exponent |
| wr_neg | input | 1 | Slope sign, 1 = negative |
| wr_base | input | YW | Signed intercept including error-balancing correction |
| out_valid | output | 1 | Result present on `out_y` |
| out_y | output | YW | Approximated function value, two's complement |

## Verification
A corrupted coefficient entry appears as a wrong `out_y` on every sample that addresses that segment, exactly 4 + USE_SHIFT + USE_NEG cycles after the sample. Other segments stay correct, which localises the fault to one entry. A wrong value in a single data pipeline register spoils one output only, at the cycle that register's sample reaches the adder. A slip in the valid chain moves `out_valid` off its fixed latency, or lets `out_y` change while `out_valid` is low; either shows at the ports on that same cycle. A bench copy with both optional stages removed shows whether the shift field and sign flag are dropped, because entries with non-zero shift or negative sign give different results there.

// File: rtl/pwl_pkg.sv
package pwl_pkg;

    // Default geometry of the evaluator
    localparam int DEF_XW  = 12;  // input / segment start width
    localparam int DEF_MW  = 8;   // slope magnitude width
    localparam int DEF_MF  = 6;   // slope fractional bits
    localparam int DEF_SHW = 2;   // shift exponent width
    localparam int DEF_AW  = 4;   // coefficient address width
    localparam int DEF_YW  = 20;  // output / intercept width

    typedef enum logic {
        SLOPE_POS = 1'b0,
        SLOPE_NEG = 1'b1
    } slope_sign_e;

    // Cycles from an accepted sample to its result
    function automatic int pipe_depth(input bit use_shift, input bit use_neg);
        return 4 + (use_shift ? 1 : 0) + (use_neg ? 1 : 0);
    endfunction

    // Width of the magnitude term after shift and truncation
    function automatic int term_width(input int xw, input int mw, input int mf, input int shw);
        return xw + mw + ((1 << shw) - 1) - mf;
    endfunction

endpackage

// File: rtl/pwl_coef_table.sv
module pwl_coef_table #(
    parameter int XW  = pwl_pkg::DEF_XW,
    parameter int MW  = pwl_pkg::DEF_MW,
    parameter int SHW = pwl_pkg::DEF_SHW,
    parameter int AW  = pwl_pkg::DEF_AW,
    parameter int YW  = pwl_pkg::DEF_YW
) (
    input  logic          clk,
    input  logic          rst,
    // write side
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [XW-1:0] wr_start,
    input  logic [MW-1:0] wr_mag,
    input  logic [SHW-1:0] wr_shift,
    input  logic          wr_neg,
    input  logic [YW-1:0] wr_base,
    // lookup side
    input  logic          rd_valid,
    input  logic [AW-1:0] rd_addr,
    input  logic [XW-1:0] rd_x,
    output logic          q_valid,
    output logic [XW-1:0] q_x,
    output logic [XW-1:0] q_start,
    output logic [MW-1:0] q_mag,
    output logic [SHW-1:0] q_shift,
    output logic          q_neg,
    output logic [YW-1:0] q_base
);
    localparam int NENT = 1 << AW;

    typedef struct packed {
        logic [XW-1:0]  start;
        logic [MW-1:0]  mag;
        logic [SHW-1:0] sh;
        pwl_pkg::slope_sign_e sign;
        logic [YW-1:0]  base;
    } coef_t;

    typedef struct packed {
        logic [XW-1:0] x;
        coef_t         c;
    } lookup_t;

    coef_t   mem [NENT];
    lookup_t look_q;
    logic    vld_q;

    // Coefficient storage: written on the edge, read registered (old data on a collision)
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= '{start: wr_start,
                              mag:   wr_mag,
                              sh:    wr_shift,
                              sign:  pwl_pkg::slope_sign_e'(wr_neg),
                              base:  wr_base};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
        end else begin
            vld_q <= rd_valid;
        end
    end

    // Sample carried alongside the entry it addressed
    always_ff @(posedge clk) begin
        if (rd_valid) begin
            look_q.x <= rd_x;
            look_q.c <= mem[rd_addr];
        end
    end

    assign q_valid = vld_q;
    assign q_x     = look_q.x;
    assign q_start = look_q.c.start;
    assign q_mag   = look_q.c.mag;
    assign q_shift = look_q.c.sh;
    assign q_neg   = (look_q.c.sign == pwl_pkg::SLOPE_NEG);
    assign q_base  = look_q.c.base;

endmodule

// File: rtl/pwl_rebase_mul.sv
module pwl_rebase_mul #(
    parameter int XW  = pwl_pkg::DEF_XW,
    parameter int MW  = pwl_pkg::DEF_MW,
    parameter int SHW = pwl_pkg::DEF_SHW,
    parameter int YW  = pwl_pkg::DEF_YW,
    localparam int PW = XW + MW
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [XW-1:0]  in_x,
    input  logic [XW-1:0]  in_start,
    input  logic [MW-1:0]  in_mag,
    input  logic [SHW-1:0] in_shift,
    input  logic           in_neg,
    input  logic [YW-1:0]  in_base,
    output logic           p_valid,
    output logic [PW-1:0]  p_prod,
    output logic [SHW-1:0] p_shift,
    output logic           p_neg,
    output logic [YW-1:0]  p_base
);
    // Stage after the subtractor
    typedef struct packed {
        logic [XW-1:0]  offs;
        logic [MW-1:0]  mag;
        logic [SHW-1:0] sh;
        logic           neg;
        logic [YW-1:0]  base;
    } rebase_t;

    // Stage after the multiplier
    typedef struct packed {
        logic [PW-1:0]  prod;
        logic [SHW-1:0] sh;
        logic           neg;
        logic [YW-1:0]  base;
    } mult_t;

    rebase_t rb_q;
    mult_t   mu_q;
    logic    rb_v, mu_v;
    logic [XW-1:0] offs_n;
    logic [PW-1:0] prod_n;

    // Offset inside the segment, modulo 2^XW
    assign offs_n = in_x - in_start;
    // Unsigned product of offset and slope magnitude
    assign prod_n = PW'(rb_q.offs) * PW'(rb_q.mag);

    always_ff @(posedge clk) begin
        if (rst) begin
            rb_v <= 1'b0;
            mu_v <= 1'b0;
        end else begin
            rb_v <= in_valid;
            mu_v <= rb_v;
        end
    end

    always_ff @(posedge clk) begin
        if (in_valid) begin
            rb_q.offs <= offs_n;
            rb_q.mag  <= in_mag;
            rb_q.sh   <= in_shift;
            rb_q.neg  <= in_neg;
            rb_q.base <= in_base;
        end
    end

    always_ff @(posedge clk) begin
        if (rb_v) begin
            mu_q.prod <= prod_n;
            mu_q.sh   <= rb_q.sh;
            mu_q.neg  <= rb_q.neg;
            mu_q.base <= rb_q.base;
        end
    end

    assign p_valid = mu_v;
    assign p_prod  = mu_q.prod;
    assign p_shift = mu_q.sh;
    assign p_neg   = mu_q.neg;
    assign p_base  = mu_q.base;

endmodule

// File: rtl/pwl_scale_sign.sv
module pwl_scale_sign #(
    parameter int XW        = pwl_pkg::DEF_XW,
    parameter int MW        = pwl_pkg::DEF_MW,
    parameter int MF        = pwl_pkg::DEF_MF,
    parameter int SHW       = pwl_pkg::DEF_SHW,
    parameter int YW        = pwl_pkg::DEF_YW,
    parameter bit USE_SHIFT = 1'b1,
    parameter bit USE_NEG   = 1'b1,
    localparam int PW  = XW + MW,
    localparam int TW  = pwl_pkg::term_width(XW, MW, MF, SHW)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [PW-1:0]  in_prod,
    input  logic [SHW-1:0] in_shift,
    input  logic           in_neg,
    input  logic [YW-1:0]  in_base,
    output logic           t_valid,
    output logic [TW:0]    t_term,
    output logic [YW-1:0]  t_base
);
    localparam int MAXSH = (1 << SHW) - 1;
    localparam int SPW   = PW + MAXSH;

    logic [SPW-1:0] sc_val;
    logic           sc_neg;
    logic [YW-1:0]  sc_base;
    logic           sc_v;

    // Optional scaling stage: product times 2^shift
    if (USE_SHIFT) begin : g_shift
        logic [SPW-1:0] val_q;
        logic           neg_q;
        logic [YW-1:0]  base_q;
        logic           v_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else begin
                v_q <= in_valid;
            end
        end

        always_ff @(posedge clk) begin
            if (in_valid) begin
                val_q  <= SPW'(in_prod) << in_shift;
                neg_q  <= in_neg;
                base_q <= in_base;
            end
        end

        assign sc_val  = val_q;
        assign sc_neg  = neg_q;
        assign sc_base = base_q;
        assign sc_v    = v_q;
    end else begin : g_noshift
        logic unused_shift;
        assign unused_shift = ^in_shift;
        assign sc_val  = SPW'(in_prod);
        assign sc_neg  = in_neg;
        assign sc_base = in_base;
        assign sc_v    = in_valid;
    end

    // Drop the slope fraction bits: magnitude truncated toward zero
    logic [TW-1:0] mag_t;
    logic [TW:0]   mag_ext;
    assign mag_t   = sc_val[SPW-1:MF];
    assign mag_ext = {1'b0, mag_t};

    // Optional two's complement stage
    if (USE_NEG) begin : g_neg
        logic [TW:0]   term_q;
        logic [YW-1:0] base_q;
        logic          v_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                v_q <= 1'b0;
            end else begin
                v_q <= sc_v;
            end
        end

        always_ff @(posedge clk) begin
            if (sc_v) begin
                term_q <= sc_neg ? ((TW+1)'(0) - mag_ext) : mag_ext;
                base_q <= sc_base;
            end
        end

        assign t_term  = term_q;
        assign t_base  = base_q;
        assign t_valid = v_q;
    end else begin : g_noneg
        logic unused_neg;
        assign unused_neg = sc_neg;
        assign t_term  = mag_ext;
        assign t_base  = sc_base;
        assign t_valid = sc_v;
    end

endmodule

// File: rtl/pwl_eval.sv
module pwl_eval #(
    parameter int XW        = pwl_pkg::DEF_XW,
    parameter int MW        = pwl_pkg::DEF_MW,
    parameter int MF        = pwl_pkg::DEF_MF,
    parameter int SHW       = pwl_pkg::DEF_SHW,
    parameter int AW        = pwl_pkg::DEF_AW,
    parameter int YW        = pwl_pkg::DEF_YW,
    parameter bit USE_SHIFT = 1'b1,
    parameter bit USE_NEG   = 1'b1
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           in_valid,
    input  logic [XW-1:0]  in_x,
    input  logic [AW-1:0]  in_idx,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [XW-1:0]  wr_start,
    input  logic [MW-1:0]  wr_mag,
    input  logic [SHW-1:0] wr_shift,
    input  logic           wr_neg,
    input  logic [YW-1:0]  wr_base,
    output logic           out_valid,
    output logic [YW-1:0]  out_y
);
    localparam int PW = XW + MW;
    localparam int TW = pwl_pkg::term_width(XW, MW, MF, SHW);

    // table -> rebase
    logic           tb_v;
    logic [XW-1:0]  tb_x, tb_start;
    logic [MW-1:0]  tb_mag;
    logic [SHW-1:0] tb_sh;
    logic           tb_neg;
    logic [YW-1:0]  tb_base;

    // multiplier -> scale/sign
    logic           mp_v;
    logic [PW-1:0]  mp_prod;
    logic [SHW-1:0] mp_sh;
    logic           mp_neg;
    logic [YW-1:0]  mp_base;

    // scale/sign -> final adder
    logic           tm_v;
    logic [TW:0]    tm_term;
    logic [YW-1:0]  tm_base;

    pwl_coef_table #(
        .XW(XW), .MW(MW), .SHW(SHW), .AW(AW), .YW(YW)
    ) u_table (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_start (wr_start),
        .wr_mag   (wr_mag),
        .wr_shift (wr_shift),
        .wr_neg   (wr_neg),
        .wr_base  (wr_base),
        .rd_valid (in_valid),
        .rd_addr  (in_idx),
        .rd_x     (in_x),
        .q_valid  (tb_v),
        .q_x      (tb_x),
        .q_start  (tb_start),
        .q_mag    (tb_mag),
        .q_shift  (tb_sh),
        .q_neg    (tb_neg),
        .q_base   (tb_base)
    );

    pwl_rebase_mul #(
        .XW(XW), .MW(MW), .SHW(SHW), .YW(YW)
    ) u_rebase_mul (
        .clk      (clk),
        .rst      (rst),
        .in_valid (tb_v),
        .in_x     (tb_x),
        .in_start (tb_start),
        .in_mag   (tb_mag),
        .in_shift (tb_sh),
        .in_neg   (tb_neg),
        .in_base  (tb_base),
        .p_valid  (mp_v),
        .p_prod   (mp_prod),
        .p_shift  (mp_sh),
        .p_neg    (mp_neg),
        .p_base   (mp_base)
    );

    pwl_scale_sign #(
        .XW(XW), .MW(MW), .MF(MF), .SHW(SHW), .YW(YW),
        .USE_SHIFT(USE_SHIFT), .USE_NEG(USE_NEG)
    ) u_scale_sign (
        .clk      (clk),
        .rst      (rst),
        .in_valid (mp_v),
        .in_prod  (mp_prod),
        .in_shift (mp_sh),
        .in_neg   (mp_neg),
        .in_base  (mp_base),
        .t_valid  (tm_v),
        .t_term   (tm_term),
        .t_base   (tm_base)
    );

    // Final adder: intercept plus sign-extended slope term
    logic [YW-1:0] sum_n;
    logic [YW-1:0] y_q;
    logic          y_v;

    assign sum_n = tm_base + {{(YW-TW-1){tm_term[TW]}}, tm_term};

    always_ff @(posedge clk) begin
        if (rst) begin
            y_v <= 1'b0;
            y_q <= '0;
        end else begin
            y_v <= tm_v;
            if (tm_v) begin
                y_q <= sum_n;
            end
        end
    end

    assign out_valid = y_v;
    assign out_y     = y_q;

endmodule

// File: rtl/pwl_eval_chk.sv
module pwl_eval_chk #(
    parameter int XW        = pwl_pkg::DEF_XW,
    parameter int AW        = pwl_pkg::DEF_AW,
    parameter int YW        = pwl_pkg::DEF_YW,
    parameter bit USE_SHIFT = 1'b1,
    parameter bit USE_NEG   = 1'b1
) (
    input logic          clk,
    input logic          rst,
    input logic          in_valid,
    input logic [XW-1:0] in_x,
    input logic [AW-1:0] in_idx,
    input logic          wr_en,
    input logic          out_valid,
    input logic [YW-1:0] out_y
);
    localparam int LAT = pwl_pkg::pipe_depth(USE_SHIFT, USE_NEG);

    // Edges seen since reset was last released, saturating
    int unsigned since_rst;
    always_ff @(posedge clk) begin
        if (rst) begin
            since_rst <= 0;
        end else if (since_rst < LAT + 1) begin
            since_rst <= since_rst + 1;
        end
    end

    // R1
    reset_clears_chk: assert property (@(posedge clk)
        rst |=> (!out_valid && out_y == '0));

    // R2
    fixed_latency_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LAT) |-> (out_valid == $past(in_valid, LAT)));

    // R7
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 1 && !out_valid) |-> $stable(out_y));

    // R3
    same_input_same_result_chk: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= LAT + 1 && out_valid &&
         $past(in_valid, LAT) && $past(in_valid, LAT + 1) &&
         $past(in_x, LAT) == $past(in_x, LAT + 1) &&
         $past(in_idx, LAT) == $past(in_idx, LAT + 1) &&
         !$past(wr_en, LAT + 1)) |-> $stable(out_y));

endmodule

bind pwl_eval pwl_eval_chk #(
    .XW(XW), .AW(AW), .YW(YW), .USE_SHIFT(USE_SHIFT), .USE_NEG(USE_NEG)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .in_x      (in_x),
    .in_idx    (in_idx),
    .wr_en     (wr_en),
    .out_valid (out_valid),
    .out_y     (out_y)
);

// File: tb/pwl_eval_test.sv
module pwl_eval_test;
    localparam int XW = 12, MW = 8, MF = 6, SHW = 2, AW = 4, YW = 20;
    localparam int NENT = 1 << AW;
    localparam int LAT  = 6;   // both optional stages present (R2)
    localparam int LATM = 4;   // both optional stages removed (R8)
    localparam longint XMASK = (longint'(1) << XW) - 1;
    localparam longint YMASK = (longint'(1) << YW) - 1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic           rst = 1'b1;
    logic           in_valid = 1'b0;
    logic [XW-1:0]  in_x = '0;
    logic [AW-1:0]  in_idx = '0;
    logic           wr_en = 1'b0;
    logic [AW-1:0]  wr_addr = '0;
    logic [XW-1:0]  wr_start = '0;
    logic [MW-1:0]  wr_mag = '0;
    logic [SHW-1:0] wr_shift = '0;
    logic           wr_neg = 1'b0;
    logic [YW-1:0]  wr_base = '0;
    logic           out_valid, m_valid;
    logic [YW-1:0]  out_y, m_y;

    pwl_eval #(.XW(XW), .MW(MW), .MF(MF), .SHW(SHW), .AW(AW), .YW(YW),
               .USE_SHIFT(1'b1), .USE_NEG(1'b1)) uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_start(wr_start), .wr_mag(wr_mag),
        .wr_shift(wr_shift), .wr_neg(wr_neg), .wr_base(wr_base),
        .out_valid(out_valid), .out_y(out_y));

    pwl_eval #(.XW(XW), .MW(MW), .MF(MF), .SHW(SHW), .AW(AW), .YW(YW),
               .USE_SHIFT(1'b0), .USE_NEG(1'b0)) uut_min (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_x(in_x), .in_idx(in_idx),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_start(wr_start), .wr_mag(wr_mag),
        .wr_shift(wr_shift), .wr_neg(wr_neg), .wr_base(wr_base),
        .out_valid(m_valid), .out_y(m_y));

    int    checks = 0;
    int    failures = 0;
    bit    finished = 1'b0;
    string cur_tag = "R1";

    // Bench copy of the coefficient entries
    longint t_s [NENT];
    longint t_m [NENT];
    longint t_sh[NENT];
    bit     t_n [NENT];
    longint t_b [NENT];

    // Expected result from the requirement formulas (R3, R4, R5, R8)
    function automatic longint model(int idx, longint x, bit ush, bit uneg);
        longint d = (x - t_s[idx]) & XMASK;
        longint p = d * t_m[idx];
        longint t;
        if (ush) p = p << t_sh[idx];
        t = p >> MF;
        if (uneg && t_n[idx]) t = -t;
        return (t_b[idx] + t) & YMASK;
    endfunction

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Expectations recorded per input cycle
    bit     ev [256];
    longint ey [256];
    longint eym[256];
    string  etag[256];
    int unsigned pcount = 0;
    longint hold_y = 0, hold_ym = 0;

    always @(posedge clk) begin
        int unsigned slot, c;
        slot = pcount % 256;
        ev[slot]   = in_valid && !rst;
        ey[slot]   = model(int'(in_idx), longint'(in_x), 1'b1, 1'b1);
        eym[slot]  = model(int'(in_idx), longint'(in_x), 1'b0, 1'b0);
        etag[slot] = cur_tag;
        // read-before-write: the mirror changes after the sample used it (R6)
        if (wr_en) begin
            t_s[wr_addr]  = longint'(wr_start);
            t_m[wr_addr]  = longint'(wr_mag);
            t_sh[wr_addr] = longint'(wr_shift);
            t_n[wr_addr]  = wr_neg;
            t_b[wr_addr]  = longint'(wr_base);
        end
        pcount++;
        #5;
        if (rst) begin
            hold_y = 0;
            hold_ym = 0;
        end else if (pcount > LAT + 1) begin
            c = (pcount - LAT) % 256;
            if (ev[c]) begin
                chk({"R2 valid ", etag[c]}, longint'(out_valid), 1);
                chk({"value ", etag[c]}, longint'(out_y), ey[c]);
                hold_y = ey[c];
            end else begin
                chk("R2 idle valid", longint'(out_valid), 0);
                chk("R7 hold", longint'(out_y), hold_y);
            end
            c = (pcount - LATM) % 256;
            if (ev[c]) begin
                chk({"R2 R8 valid ", etag[c]}, longint'(m_valid), 1);
                chk({"R8 value ", etag[c]}, longint'(m_y), eym[c]);
                hold_ym = eym[c];
            end else begin
                chk("R2 R8 idle valid", longint'(m_valid), 0);
                chk("R7 R8 hold", longint'(m_y), hold_ym);
            end
        end
    end

    task automatic write_entry(int a, longint s, longint m, longint sh, bit n, longint b);
        @(negedge clk);
        wr_en    = 1'b1;
        wr_addr  = AW'(a);
        wr_start = XW'(s);
        wr_mag   = MW'(m);
        wr_shift = SHW'(sh);
        wr_neg   = n;
        wr_base  = YW'(b);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic drain();
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT + 3) @(negedge clk);
    endtask

    // R1: reset state at the ports
    task automatic t_reset();
        cur_tag = "R1";
        rst = 1'b1;
        repeat (8) @(negedge clk);
        chk("R1 valid during reset", longint'(out_valid), 0);
        chk("R1 y during reset", longint'(out_y), 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 valid after release", longint'(out_valid), 0);
        chk("R1 y after release", longint'(out_y), 0);
        chk("R1 min valid after release", longint'(m_valid), 0);
    endtask

    // R6: program every entry, mixing signs and shifts
    task automatic t_program();
        cur_tag = "R6";
        for (int k = 0; k < NENT; k++) begin
            write_entry(k, k * 256, 17 + k * 13, k % 4, (k % 3) == 1,
                        (longint'(k) * 40000 - 300000) & YMASK);
        end
    endtask

    // R3 R4 R5: back-to-back samples inside their segments
    task automatic t_stream();
        cur_tag = "R3 R4 R5";
        for (int n = 0; n < 300; n++) begin
            int k;
            @(negedge clk);
            k = $urandom_range(NENT - 1);
            in_valid = 1'b1;
            in_idx   = AW'(k);
            in_x     = XW'(t_s[k] + longint'($urandom_range(255)));
        end
        drain();
    endtask

    // R7: sparse samples with gaps
    task automatic t_bubbles();
        cur_tag = "R7";
        for (int n = 0; n < 200; n++) begin
            int k;
            @(negedge clk);
            k = $urandom_range(NENT - 1);
            in_valid = ($urandom_range(2) == 0);
            in_idx   = AW'(k);
            in_x     = XW'(t_s[k] + longint'($urandom_range(255)));
        end
        drain();
    endtask

    // R6: write into an entry on the same edge as a lookup of it, then after
    task automatic t_write_race();
        cur_tag = "R6";
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_idx   = AW'(5);
            in_x     = XW'(t_s[5] + 40 + r);
            wr_en    = 1'b1;
            wr_addr  = AW'(5);
            wr_start = XW'(t_s[5] + 1);
            wr_mag   = MW'(t_m[5] + 37);
            wr_shift = SHW'(t_sh[5] + 1);
            wr_neg   = ~t_n[5];
            wr_base  = YW'(t_b[5] + 1000);
            @(negedge clk);
            wr_en    = 1'b0;
            in_idx   = AW'(5);
            in_x     = XW'(t_s[5] + 41 + r);
            @(negedge clk);
            in_idx   = AW'(6);
            in_x     = XW'(t_s[6] + 3);
        end
        drain();
    endtask

    // R3 R4: offset wrap below the start and output wrap at full scale
    task automatic t_wrap();
        cur_tag = "R3 R4 wrap";
        write_entry(9, 2000, 255, 3, 1'b0, YMASK - 5);
        write_entry(10, 3000, 255, 3, 1'b1, 7);
        write_entry(11, 0, 0, 0, 1'b1, 12345);
        for (int n = 0; n < 24; n++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_idx   = AW'(9 + (n % 3));
            in_x     = XW'((n * 331 + 1995) & XMASK);
        end
        drain();
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < NENT; k++) begin
            t_s[k] = 0; t_m[k] = 0; t_sh[k] = 0; t_n[k] = 0; t_b[k] = 0;
        end
        t_reset();
        t_program();
        t_stream();
        t_bubbles();
        t_write_race();
        t_wrap();
        t_stream();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule